// File: doc/BRIEF.md
# Clock Output Enable Power Controller

This block is the digital control core of a five-output differential clock fanout buffer. It takes the incoming reference clock and produces a gated true/complement pair for every output. An output runs only when the device is powered up, the output's register enable bit is set, and its active-low enable pin is driven low. In every other case both sides of that pair sit low. All gating decisions are timed against the reference clock, so an output never starts or stops with a shortened pulse on either side.

The same block also derives the device's 7-bit SMBus slave address. The first time the power-good/power-down input goes high, it captures a three-level address strap and holds the resulting address until the next full reset. Later power-down and power-up cycles leave the address alone.

The enable register is loaded through a plain parallel write strobe. It resets to all ones, so the device works without any bus access. No data stream crosses the block's edge, so it has no valid/ready interface. Every control pin is a plain level.

Top module: `ckoe_ctrl`

## Requirements
- R1: While `rst_n` is low, every `clk_out_p`/`clk_out_n` bit is 0 and `addr_valid` is 0. After reset every enable register bit is 1, so with power good high and all pins low, all five outputs run with no register write.
- R2: While the synchronized power-good input is low, every output holds both its true and its complement side at 0.
- R3: With power good high, output i runs only when enable register bit i is 1 and `oe_pin_n[i]` is 0. The other three combinations of that bit and pin hold both sides of output i at 0.
- R4: `addr_valid` rises on the first clock after synchronized power-good is first seen high. From then until reset it stays 1 and `slave_addr` does not change, even across later power-down/power-up cycles and strap changes.
- R5: The latched address depends on `strap_lvl`. 2'b00 gives 7'b1101011, 2'b01 gives 7'b1101100, and 2'b10 or 2'b11 gives 7'b1101101.
- R6: When `cfg_we` is 1 at a rising `clk_ref` edge, `cfg_wdata[i]` becomes the enable register bit of output i. When `cfg_we` is 0, the register holds its value.
- R7: `pwr_good` and `oe_pin_n` each pass through two reference-clock flops. If one of them changes after rising edge P0, the true output first reflects the change in the high phase that starts at the third rising edge after P0.
- R8: Every high pulse on any `clk_out_p` or `clk_out_n` bit lasts exactly half a reference clock period, including the first and last pulse when an output starts or stops.
- R9: While an output runs, its complement is the inverse of `clk_ref`. When the output is gated, the complement is held at 0 rather than inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, both source of the outputs and clock of all control flops |
| rst_n | input | 1 | Asynchronous active-low full reset |
| pwr_good | input | 1 | Power-good/power-down level: high runs the device, low powers it down |
| oe_pin_n | input | N_OUT | Per-output active-low enable pins (0 enables, 1 disables) |
| strap_lvl | input | 2 | Encoded address strap level: 00 low, 01 mid, 10 high |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | N_OUT | New enable register value, bit i for output i |
| clk_out_p | output | N_OUT | True side of each gated clock output |
| clk_out_n | output | N_OUT | Complement side of each gated clock output |
| addr_valid | output | 1 | High once the address strap has been captured |
| slave_addr | output | 7 | Latched 7-bit slave address |

## Verification
The bench checks each of the eight combinations of power good, register bit and pin, plus mixed per-output patterns. A design that dropped one of the three gating terms would leave an output running when it should be dark. Pulse widths are timed on every edge of both sides, so gating that changed while the clock was high would show up as a runt on the true or the complement side. The address is checked for all four strap codes, and again after the strap is changed and power is cycled. A design that resampled the strap on power-up would then report a different address. An explicit latency check catches a synchronizer that is one flop short or one flop long.

// File: rtl/ckoe_pkg.sv
package ckoe_pkg;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 7'b1101011;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_MID  = 2'b01,
    STRAP_HIGH = 2'b10,
    STRAP_RSVD = 2'b11
  } strap_lvl_e;

  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [1:0] lvl);
    logic [ADDR_W-1:0] a;
    case (strap_lvl_e'(lvl))
      STRAP_LOW: a = ADDR_BASE;
      STRAP_MID: a = ADDR_BASE + 7'd1;
      default:   a = ADDR_BASE + 7'd2;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/ckoe_sync.sv
module ckoe_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ckoe_addr_latch.sv
module ckoe_addr_latch
  import ckoe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_s,
  input  logic [1:0]        strap,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] slave_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      slave_addr <= '0;
    end else if (!addr_valid && pg_s) begin
      addr_valid <= 1'b1;
      slave_addr <= strap_to_addr(strap);
    end
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (addr_valid && $stable(slave_addr)));

  // R4
  first_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> $past(pg_s));
endmodule

// File: rtl/ckoe_cfg_reg.sv
module ckoe_cfg_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '1;
    else if (we) cfg <= wdata;
  end

  // R6
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg == $past(wdata)));

  // R6
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
endmodule

// File: rtl/ckoe_out_gate.sv
module ckoe_out_gate #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pg_s,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] cfg,
  output logic [N-1:0] out_p,
  output logic [N-1:0] out_n
);
  logic [N-1:0] gate_p;  // changes only while clk is low
  logic [N-1:0] gate_n;  // changes only while clk is high

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic want;
    assign want = pg_s & cfg[i] & ~pin_s[i];

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_p[i] <= 1'b0;
      else        gate_p[i] <= want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_n[i] <= 1'b0;
      else        gate_n[i] <= gate_p[i];
    end

    assign out_p[i] = clk  & gate_p[i];
    assign out_n[i] = ~clk & gate_n[i];

    // R3
    pin_blocks_chk: assert property (@(negedge clk) disable iff (!rst_n)
      pin_s[i] |=> !gate_p[i]);

    // R3
    cfg_blocks_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !cfg[i] |=> !gate_p[i]);

    // R3
    lane_runs_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (pg_s && cfg[i] && !pin_s[i]) |=> gate_p[i]);
  end

  // R2
  pd_forces_off_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !pg_s |=> (gate_p == '0));

  // R9
  comp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gate_n == $past(gate_p)));
endmodule

// File: rtl/ckoe_ctrl.sv
module ckoe_ctrl
  import ckoe_pkg::*;
#(
  parameter int N_OUT = 5
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [N_OUT-1:0]  oe_pin_n,
  input  logic [1:0]        strap_lvl,
  input  logic              cfg_we,
  input  logic [N_OUT-1:0]  cfg_wdata,
  output logic [N_OUT-1:0]  clk_out_p,
  output logic [N_OUT-1:0]  clk_out_n,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] slave_addr
);
  localparam logic [N_OUT-1:0] PIN_IDLE = '1;

  logic              pg_s;
  logic [N_OUT-1:0]  pin_s;
  logic [N_OUT-1:0]  cfg;

  ckoe_sync #(.W(1), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(pwr_good), .q(pg_s)
  );

  ckoe_sync #(.W(N_OUT), .RST_VAL(PIN_IDLE)) u_pin_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(oe_pin_n), .q(pin_s)
  );

  ckoe_addr_latch u_addr (
    .clk(clk_ref), .rst_n(rst_n), .pg_s(pg_s), .strap(strap_lvl),
    .addr_valid(addr_valid), .slave_addr(slave_addr)
  );

  ckoe_cfg_reg #(.N(N_OUT)) u_cfg (
    .clk(clk_ref), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  ckoe_out_gate #(.N(N_OUT)) u_gate (
    .clk(clk_ref), .rst_n(rst_n), .pg_s(pg_s), .pin_s(pin_s), .cfg(cfg),
    .out_p(clk_out_p), .out_n(clk_out_n)
  );
endmodule

// File: tb/test_ckoe_ctrl.sv
`timescale 1ns/1ps
module test_ckoe_ctrl;
  localparam real PERIOD = 10.0;
  localparam int  N = 5;

  logic         clk_ref = 1'b0;
  logic         rst_n;
  logic         pwr_good;
  logic [N-1:0] oe_pin_n;
  logic [1:0]   strap_lvl;
  logic         cfg_we;
  logic [N-1:0] cfg_wdata;
  logic [N-1:0] clk_out_p, clk_out_n;
  logic         addr_valid;
  logic [6:0]   slave_addr;

  int tests = 0;
  int fails = 0;

  ckoe_ctrl #(.N_OUT(N)) i_ckoe_ctrl (
    .clk_ref(clk_ref), .rst_n(rst_n), .pwr_good(pwr_good), .oe_pin_n(oe_pin_n),
    .strap_lvl(strap_lvl), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clk_out_p(clk_out_p), .clk_out_n(clk_out_n),
    .addr_valid(addr_valid), .slave_addr(slave_addr)
  );

  initial forever #(PERIOD/2.0) clk_ref = ~clk_ref;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int pg_hist[$];
  int pin_hist[$];
  int m_cfg, m_valid, m_addr;
  int e_p, e_n;

  function automatic int addr_of(input int s);
    int k;
    k = (s > 2) ? 2 : s;
    return 'h6B + k;
  endfunction

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pg_hist  = '{0, 0};
      pin_hist = '{31, 31};
      m_cfg = 31; m_valid = 0; m_addr = 0; e_n = 0;
    end else begin
      if (!m_valid && pg_hist[0] != 0) begin
        m_valid = 1;
        m_addr  = addr_of(int'(strap_lvl));
      end
      e_n = e_p;
      if (cfg_we) m_cfg = int'(cfg_wdata);
      void'(pg_hist.pop_front());
      pg_hist.push_back(int'(pwr_good));
      void'(pin_hist.pop_front());
      pin_hist.push_back(int'(oe_pin_n));
    end
  end

  always @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) e_p = 0;
    else if (clk_ref == 1'b0) e_p = (pg_hist[0] != 0) ? (m_cfg & ~pin_hist[0] & 31) : 0;
  end

  // compare every clock, both phases
  always @(posedge clk_ref) begin
    #(PERIOD/4.0);
    chk(clk_out_p == N'(e_p), "R3", "true side in high phase", 32'(clk_out_p), 32'(e_p));
    chk(clk_out_n == '0, "R9", "complement in high phase", 32'(clk_out_n), 0);
    chk(addr_valid == m_valid[0], "R4", "addr_valid", 32'(addr_valid), 32'(m_valid));
    if (m_valid != 0)
      chk(slave_addr == 7'(m_addr), "R5", "slave_addr", 32'(slave_addr), 32'(m_addr));
  end

  always @(negedge clk_ref) begin
    #(PERIOD/4.0);
    chk(clk_out_p == '0, "R9", "true side in low phase", 32'(clk_out_p), 0);
    chk(clk_out_n == N'(e_n), "R9", "complement in low phase", 32'(clk_out_n), 32'(e_n));
  end

  // pulse width monitor (R8)
  realtime tp[N];
  realtime tn[N];
  logic [N-1:0] pp = '0, pn = '0;
  always @(clk_out_p or clk_out_n) begin
    for (int i = 0; i < N; i++) begin
      if (clk_out_p[i] === 1'b1 && pp[i] !== 1'b1) tp[i] = $realtime;
      if (clk_out_p[i] === 1'b0 && pp[i] === 1'b1)
        chk(($realtime - tp[i]) == PERIOD/2.0, "R8", "true pulse width ps",
            32'(int'(($realtime - tp[i]) * 1000)), 32'(int'(PERIOD * 500)));
      if (clk_out_n[i] === 1'b1 && pn[i] !== 1'b1) tn[i] = $realtime;
      if (clk_out_n[i] === 1'b0 && pn[i] === 1'b1)
        chk(($realtime - tn[i]) == PERIOD/2.0, "R8", "complement pulse width ps",
            32'(int'(($realtime - tn[i]) * 1000)), 32'(int'(PERIOD * 500)));
    end
    pp = clk_out_p;
    pn = clk_out_n;
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk_ref);
    #2;
  endtask

  task automatic wr_cfg(input logic [N-1:0] v);
    step(1);
    cfg_we = 1'b1; cfg_wdata = v;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic at_high;
    @(posedge clk_ref);
    #(PERIOD/4.0);
  endtask

  task automatic full_reset;
    pwr_good = 1'b0;
    step(6);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic combo(input bit pg, input logic [N-1:0] c, input logic [N-1:0] pin,
                       input string req);
    logic [N-1:0] want;
    pwr_good = pg;
    wr_cfg(c);
    oe_pin_n = pin;
    step(6);
    want = pg ? (c & ~pin) : '0;
    at_high;
    chk(clk_out_p == want, req, "combination true side", 32'(clk_out_p), 32'(want));
    chk(clk_out_n == '0, req, "combination complement high phase", 32'(clk_out_n), 0);
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; oe_pin_n = '1; strap_lvl = 2'b00;
    cfg_we = 1'b0; cfg_wdata = '0;
    step(4);
    at_high;
    chk(clk_out_p == '0 && clk_out_n == '0, "R1", "outputs in reset",
        32'({clk_out_p, clk_out_n}), 0);
    chk(addr_valid == 1'b0, "R1", "addr_valid in reset", 32'(addr_valid), 0);
    step(1);
    rst_n = 1'b1;

    // no capture before power good (R4)
    step(6);
    chk(addr_valid == 1'b0, "R4", "valid before power good", 32'(addr_valid), 0);

    // default enables (R1)
    pwr_good = 1'b1; oe_pin_n = '0;
    step(6);
    at_high;
    chk(clk_out_p == '1, "R1", "default register enables all", 32'(clk_out_p), 32'h1f);

    // all eight combinations on every lane (R2, R3, R6)
    for (int k = 0; k < 8; k++) begin
      combo(k[2], {N{k[1]}}, {N{k[0]}}, k[2] ? "R3" : "R2");
    end

    // mixed per-lane patterns (R3, R6)
    combo(1'b1, 5'b10110, 5'b01100, "R6");
    combo(1'b1, 5'b01011, 5'b00010, "R3");
    combo(1'b0, 5'b11111, 5'b00000, "R2");
    combo(1'b1, 5'b11111, 5'b10101, "R3");

    // latency through synchronizers (R7)
    combo(1'b1, 5'b11111, 5'b11111, "R3");
    step(1);
    oe_pin_n[0] = 1'b0;
    @(posedge clk_ref); @(posedge clk_ref); #(PERIOD/4.0);
    chk(clk_out_p[0] == 1'b0, "R7", "still off at second edge", 32'(clk_out_p[0]), 0);
    at_high;
    chk(clk_out_p[0] == 1'b1, "R7", "running at third edge", 32'(clk_out_p[0]), 1);
    step(1);
    pwr_good = 1'b0;
    @(posedge clk_ref); @(posedge clk_ref); #(PERIOD/4.0);
    chk(clk_out_p[0] == 1'b1, "R7", "still on at second edge after power down", 32'(clk_out_p[0]), 1);
    at_high;
    chk(clk_out_p[0] == 1'b0, "R7", "off at third edge after power down", 32'(clk_out_p[0]), 0);

    // address for every strap code, held across power cycles (R4, R5)
    for (int s = 0; s < 4; s++) begin
      full_reset;
      strap_lvl = 2'(s);
      oe_pin_n = '0;
      step(2);
      pwr_good = 1'b1;
      step(6);
      chk(addr_valid == 1'b1, "R4", "valid after power good", 32'(addr_valid), 1);
      chk(slave_addr == 7'(addr_of(s)), "R5", "strap address", 32'(slave_addr), 32'(addr_of(s)));
      strap_lvl = 2'(3 - s);
      pwr_good = 1'b0;
      step(8);
      pwr_good = 1'b1;
      step(8);
      chk(slave_addr == 7'(addr_of(s)), "R4", "address kept over power cycle",
          32'(slave_addr), 32'(addr_of(s)));
    end

    pwr_good = 1'b0;
    step(6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000.0);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule